// File: doc/BRIEF.md
# Paced Host Byte Buffer

This block is an eight-deep byte queue placed between a register-mapped host port and a serial-bus byte engine. While a write transfer is running, the host stores outgoing bytes with a write strobe and the engine drains them through a valid/ready output stream. While a read transfer is running, the engine fills the queue through a valid/ready input stream and the host collects bytes with a read strobe. Each host byte travels in the top eight bits of a 64-bit data word.

Every host access is checked against the current transfer. A wrong-direction access or an access with no transfer running sets an invalid-access flag. An access that meets a full or empty queue sets an overrun flag, unless pacing mode is on, in which case the access is dropped with no flag. A host-side residual counter is loaded at transfer start and counts down on each accepted host access. An access that finds it already at zero sets an access flag. A clear strobe empties the queue and resets the flags and the residual. Occupancy is always visible as an 8-bit status field.

Back-pressure rules: the engine's input stream moves a byte only when `bus_in_valid` and `bus_in_ready` are both high in the same cycle. The output stream works the same way with `bus_out_valid` and `bus_out_ready`. `bus_out_valid` and `bus_out_data` do not depend on `bus_out_ready`. Either side may hold its valid or ready line for as many cycles as it likes.

Top module: `paced_byte_fifo`

## Requirements
- R1: After reset, occupancy, residual, all three error flags, `host_rd_word`, `bus_out_valid` and `bus_in_ready` are all zero.
- R2: A host write is accepted only while a transfer is active and `xfer_is_read` is 0. A host read is accepted only while a transfer is active and `xfer_is_read` is 1. Any other host access sets `err_invalid` and changes neither the stored data, the occupancy nor the residual.
- R3: Bytes leave in the order they entered, in both directions. A host write takes its byte from bits 63:56 of `host_wr_word`. An accepted host read puts the head byte in bits 63:56 of `host_rd_word`, with bits 55:0 at zero, from the cycle after the strobe. That value holds until the next accepted read.
- R4: Full and empty are judged by the occupancy before the cycle. A host write to a full queue, or a host read from an empty one, sets `err_overrun` when `pace_en` is 0 and sets no flag when `pace_en` is 1. In both cases storage, occupancy, residual and `host_rd_word` are unchanged.
- R5: `occupancy` equals the number of stored bytes and reflects an access from the cycle after it.
- R6: `res_load` sets the residual to `res_init`. Each accepted host access lowers it by one. An accepted access that finds it at zero still moves the byte, sets `err_access`, and leaves the residual at zero. Engine-side transfers do not change the residual.
- R7: `err_clear` empties the queue, zeroes the residual and clears all three flags in the next cycle. It overrides any host access or load in the same cycle. While it is high, `bus_in_ready` and `bus_out_valid` are low.
- R8: A host access and an engine handshake in the same cycle are both serviced. Occupancy changes by the net amount, so one push and one pop leave it unchanged.
- R9: `bus_in_ready` is high only during an active read transfer with the queue not full. `bus_out_valid` is high only during an active write transfer with the queue not empty. A stalled engine side never sets a flag.
- R10: Error flags stay set until `err_clear` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_active | input | 1 | A transfer is in progress |
| xfer_is_read | input | 1 | The transfer in progress reads from the bus |
| pace_en | input | 1 | Drop full/empty host accesses silently |
| err_clear | input | 1 | Flush queue, zero residual, clear flags |
| res_load | input | 1 | Load the residual counter |
| res_init | input | 16 | Value loaded into the residual |
| host_wr | input | 1 | Host write strobe |
| host_wr_word | input | 64 | Host write word, byte in bits 63:56 |
| host_rd | input | 1 | Host read strobe |
| host_rd_word | output | 64 | Last byte read, in bits 63:56 |
| bus_in_valid | input | 1 | Engine offers a received byte |
| bus_in_ready | output | 1 | Queue accepts a received byte |
| bus_in_data | input | 8 | Received byte |
| bus_out_valid | output | 1 | Queue offers a byte to send |
| bus_out_ready | input | 1 | Engine takes the byte to send |
| bus_out_data | output | 8 | Byte to send |
| occupancy | output | 8 | Stored byte count |
| residual | output | 16 | Remaining host-side byte count |
| err_invalid | output | 1 | Sticky invalid-access flag |
| err_overrun | output | 1 | Sticky overrun flag |
| err_access | output | 1 | Sticky residual-exhausted flag |

## Verification
The assertions assume that the direction and activity inputs, together with `pace_en`, describe one coherent transfer. Each strobe is a one-cycle pulse judged against those levels. The stimulus changes mode inputs only between accesses and on the falling clock edge. It raises the engine-side valid and ready lines only in phases where the transfer direction gives them meaning, and it overlaps a host access with an engine handshake only in the one scenario meant to test that overlap.

// File: rtl/pbf_pkg.sv
`timescale 1ns/1ps
package pbf_pkg;
  // Outcome of checking the host strobes against the current transfer.
  typedef struct packed {
    logic push_ok;
    logic pop_ok;
    logic set_inv;
    logic set_ovr;
  } pbf_verdict_t;
endpackage

// File: rtl/pbf_store.sv
`timescale 1ns/1ps
module pbf_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DATA_W-1:0] slot [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign rd_data = slot[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && !flush && wr_ptr == PTR_W'(i)) slot[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pbf_access.sv
`timescale 1ns/1ps
module pbf_access
  import pbf_pkg::*;
(
  input  logic         host_push,
  input  logic         host_pop,
  input  logic         active,
  input  logic         is_read,
  input  logic         pace,
  input  logic         full,
  input  logic         empty,
  input  logic         clr,
  output pbf_verdict_t verdict
);
  logic wr_dir, rd_dir;
  assign wr_dir = active & ~is_read;
  assign rd_dir = active & is_read;

  always_comb begin
    verdict = '0;
    if (!clr) begin
      if (host_push) begin
        if (!wr_dir)   verdict.set_inv = 1'b1;
        else if (full) verdict.set_ovr = ~pace;
        else           verdict.push_ok = 1'b1;
      end
      if (host_pop) begin
        if (!rd_dir)    verdict.set_inv = 1'b1;
        else if (empty) verdict.set_ovr = verdict.set_ovr | ~pace;
        else            verdict.pop_ok  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbf_residual.sv
`timescale 1ns/1ps
module pbf_residual #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [RES_W-1:0] load_val,
  input  logic             dec,
  output logic [RES_W-1:0] value,
  output logic             exhausted
);
  assign exhausted = dec & ~load & ~clr & (value == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  value <= '0;
    else if (clr)                value <= '0;
    else if (load)               value <= load_val;
    else if (dec && value != '0) value <= value - 1'b1;
  end
endmodule

// File: rtl/paced_byte_fifo.sv
`timescale 1ns/1ps
module paced_byte_fifo
  import pbf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int WORD_W = 64,
  parameter int RES_W  = 16,
  parameter int OCC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_active,
  input  logic              xfer_is_read,
  input  logic              pace_en,
  input  logic              err_clear,
  input  logic              res_load,
  input  logic [RES_W-1:0]  res_init,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wr_word,
  input  logic              host_rd,
  output logic [WORD_W-1:0] host_rd_word,
  input  logic              bus_in_valid,
  output logic              bus_in_ready,
  input  logic [DATA_W-1:0] bus_in_data,
  output logic              bus_out_valid,
  input  logic              bus_out_ready,
  output logic [DATA_W-1:0] bus_out_data,
  output logic [OCC_W-1:0]  occupancy,
  output logic [RES_W-1:0]  residual,
  output logic              err_invalid,
  output logic              err_overrun,
  output logic              err_access
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LOW_W  = WORD_W - DATA_W;

  logic [CNT_W-1:0]  count;
  logic              full, empty;
  logic [DATA_W-1:0] head, wr_data;
  logic              wr_en, rd_en, bus_push, bus_pop, exhausted;
  pbf_verdict_t      verdict;

  assign bus_in_ready  = xfer_active &  xfer_is_read & ~full  & ~err_clear;
  assign bus_out_valid = xfer_active & ~xfer_is_read & ~empty & ~err_clear;
  assign bus_push      = bus_in_valid & bus_in_ready;
  assign bus_pop       = bus_out_valid & bus_out_ready;
  assign bus_out_data  = head;

  // Direction gating keeps host and engine on opposite ends of the queue.
  assign wr_en   = verdict.push_ok | bus_push;
  assign rd_en   = verdict.pop_ok  | bus_pop;
  assign wr_data = verdict.push_ok ? host_wr_word[WORD_W-1 -: DATA_W] : bus_in_data;

  assign occupancy = OCC_W'(count);

  pbf_access u_access (
    .host_push (host_wr),
    .host_pop  (host_rd),
    .active    (xfer_active),
    .is_read   (xfer_is_read),
    .pace      (pace_en),
    .full      (full),
    .empty     (empty),
    .clr       (err_clear),
    .verdict   (verdict)
  );

  pbf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (err_clear),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (head),
    .count   (count),
    .full    (full),
    .empty   (empty)
  );

  pbf_residual #(.RES_W(RES_W)) u_residual (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (err_clear),
    .load      (res_load),
    .load_val  (res_init),
    .dec       (verdict.push_ok | verdict.pop_ok),
    .value     (residual),
    .exhausted (exhausted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_invalid <= 1'b0;
      err_overrun <= 1'b0;
      err_access  <= 1'b0;
    end else if (err_clear) begin
      err_invalid <= 1'b0;
      err_overrun <= 1'b0;
      err_access  <= 1'b0;
    end else begin
      err_invalid <= err_invalid | verdict.set_inv;
      err_overrun <= err_overrun | verdict.set_ovr;
      err_access  <= err_access  | exhausted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              host_rd_word <= '0;
    else if (verdict.pop_ok) host_rd_word <= {head, {LOW_W{1'b0}}};
  end
endmodule

// File: rtl/pbf_checker.sv
`timescale 1ns/1ps
module pbf_checker #(
  parameter int DEPTH = 8,
  parameter int RES_W = 16,
  parameter int OCC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_active,
  input logic             xfer_is_read,
  input logic             pace_en,
  input logic             err_clear,
  input logic             res_load,
  input logic             host_wr,
  input logic             host_rd,
  input logic             bus_in_ready,
  input logic             bus_out_valid,
  input logic             bus_out_ready,
  input logic [OCC_W-1:0] occupancy,
  input logic [RES_W-1:0] residual,
  input logic             err_invalid,
  input logic             err_overrun,
  input logic             err_access
);
  logic wdir;
  assign wdir = xfer_active & ~xfer_is_read;

  p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_W'(DEPTH));

  p_bad_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !wdir && !err_clear) |=> err_invalid);

  p_bad_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !(xfer_active && xfer_is_read) && !err_clear) |=> err_invalid);

  p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && wdir && occupancy == OCC_W'(DEPTH) && !pace_en && !err_clear) |=> err_overrun);

  p_paced_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && wdir && occupancy == OCC_W'(DEPTH) && pace_en && !err_clear
     && !bus_out_ready && !err_overrun) |=> (!err_overrun && occupancy == OCC_W'(DEPTH)));

  p_exhausted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && wdir && occupancy < OCC_W'(DEPTH) && !err_clear && !res_load
     && residual == '0) |=> (err_access && residual == '0));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |=> (occupancy == '0 && residual == '0 && !err_invalid && !err_overrun && !err_access));

  p_net_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && wdir && occupancy < OCC_W'(DEPTH) && occupancy != '0 && bus_out_ready
     && !err_clear) |=> $stable(occupancy));

  p_in_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_in_ready |-> (xfer_active && xfer_is_read && occupancy < OCC_W'(DEPTH)));

  p_out_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> (wdir && occupancy != '0));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overrun && !err_clear) |=> err_overrun);
endmodule

bind paced_byte_fifo pbf_checker #(.DEPTH(DEPTH), .RES_W(RES_W), .OCC_W(OCC_W)) u_pbf_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .xfer_active   (xfer_active),
  .xfer_is_read  (xfer_is_read),
  .pace_en       (pace_en),
  .err_clear     (err_clear),
  .res_load      (res_load),
  .host_wr       (host_wr),
  .host_rd       (host_rd),
  .bus_in_ready  (bus_in_ready),
  .bus_out_valid (bus_out_valid),
  .bus_out_ready (bus_out_ready),
  .occupancy     (occupancy),
  .residual      (residual),
  .err_invalid   (err_invalid),
  .err_overrun   (err_overrun),
  .err_access    (err_access)
);

// File: tb/test_paced_byte_fifo.sv
`timescale 1ns/1ps
module test_paced_byte_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_active = 0, xfer_is_read = 0, pace_en = 0, err_clear = 0;
  logic        res_load = 0;
  logic [15:0] res_init = '0;
  logic        host_wr = 0, host_rd = 0;
  logic [63:0] host_wr_word = '0;
  logic [63:0] host_rd_word;
  logic        bus_in_valid = 0, bus_in_ready;
  logic [7:0]  bus_in_data = '0;
  logic        bus_out_valid, bus_out_ready = 0;
  logic [7:0]  bus_out_data;
  logic [7:0]  occupancy;
  logic [15:0] residual;
  logic        err_invalid, err_overrun, err_access;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] wq[$];
  logic [7:0] rq[$];
  logic [7:0] last_rd = '0;

  always #2 clk = ~clk;

  paced_byte_fifo i_paced_byte_fifo (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .xfer_is_read(xfer_is_read),
    .pace_en(pace_en), .err_clear(err_clear), .res_load(res_load), .res_init(res_init),
    .host_wr(host_wr), .host_wr_word(host_wr_word), .host_rd(host_rd),
    .host_rd_word(host_rd_word), .bus_in_valid(bus_in_valid), .bus_in_ready(bus_in_ready),
    .bus_in_data(bus_in_data), .bus_out_valid(bus_out_valid), .bus_out_ready(bus_out_ready),
    .bus_out_data(bus_out_data), .occupancy(occupancy), .residual(residual),
    .err_invalid(err_invalid), .err_overrun(err_overrun), .err_access(err_access)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Monitor: sample handshakes that the next rising edge will complete.
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n && bus_out_valid && bus_out_ready) begin
      if (wq.size() == 0) chk("R3 unexpected send byte", {56'h0, bus_out_data}, 64'hFFFF);
      else                chk("R3 send order", {56'h0, bus_out_data}, {56'h0, wq.pop_front()});
    end
    if (rst_n && bus_in_valid && bus_in_ready) rq.push_back(bus_in_data);
  end

  task automatic host_write(input logic [7:0] b, input bit ok);
    @(negedge clk);
    host_wr = 1; host_wr_word = {b, 56'h5A_A5_3C_C3_96_69_0F};
    if (ok) wq.push_back(b);
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic host_read(input bit ok, input string tag);
    logic [7:0] e;
    @(negedge clk);
    host_rd = 1;
    e = (ok && rq.size() != 0) ? rq.pop_front() : last_rd;
    @(negedge clk);
    host_rd = 0;
    chk(tag, host_rd_word, {e, 56'h0});
    last_rd = e;
  endtask

  task automatic bus_push(input logic [7:0] b);
    @(negedge clk); bus_in_valid = 1; bus_in_data = b;
    @(negedge clk); bus_in_valid = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); err_clear = 1; wq.delete(); rq.delete();
    @(negedge clk); err_clear = 0;
  endtask

  task automatic load(input logic [15:0] n);
    @(negedge clk); res_load = 1; res_init = n;
    @(negedge clk); res_load = 0;
  endtask

  task automatic drain();
    @(negedge clk); bus_out_ready = 1;
    while (occupancy != 0) @(negedge clk);
    bus_out_ready = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 occupancy", occupancy, 0);
    chk("R1 residual", residual, 0);
    chk("R1 flags", {err_invalid, err_overrun, err_access}, 0);
    chk("R1 read word", host_rd_word, 0);
    chk("R1 stream lines", {bus_out_valid, bus_in_ready}, 0);

    // No transfer: host write is invalid and stores nothing.
    host_write(8'h11, 0);
    chk("R2 idle write flag", err_invalid, 1);
    chk("R2 idle write occupancy", occupancy, 0);
    @(negedge clk);
    chk("R10 flag held", err_invalid, 1);
    clear_all();
    chk("R7 flags cleared", {err_invalid, err_overrun, err_access}, 0);

    // Write transfer, no pacing.
    xfer_active = 1; xfer_is_read = 0; pace_en = 0;
    load(16'd10);
    chk("R6 load", residual, 10);
    for (int i = 0; i < 3; i++) host_write(8'hA0 + 8'(i), 1);
    chk("R5 occupancy after three", occupancy, 3);
    chk("R6 residual after three", residual, 7);
    host_read(0, "R2 wrong-direction read word");
    chk("R2 wrong-direction read flag", err_invalid, 1);
    chk("R2 wrong-direction read occupancy", occupancy, 3);
    for (int i = 3; i < 8; i++) host_write(8'hA0 + 8'(i), 1);
    chk("R5 occupancy full", occupancy, 8);
    host_write(8'hEE, 0);
    chk("R4 overrun flag", err_overrun, 1);
    chk("R4 overrun occupancy", occupancy, 8);
    chk("R4 overrun residual", residual, 2);
    drain();
    chk("R3 all sent", wq.size(), 0);
    clear_all();
    chk("R7 occupancy", occupancy, 0);
    chk("R7 residual", residual, 0);
    chk("R7 flags", {err_invalid, err_overrun, err_access}, 0);

    // Pacing: the ninth write is dropped silently.
    pace_en = 1;
    load(16'd10);
    for (int i = 0; i < 8; i++) host_write(8'hB0 + 8'(i), 1);
    host_write(8'hB8, 0);
    chk("R4 paced no flag", err_overrun, 0);
    chk("R4 paced occupancy", occupancy, 8);
    chk("R4 paced residual", residual, 2);
    drain();
    chk("R3 paced bytes sent", wq.size(), 0);
    // Clear overriding a same-cycle host write.
    host_write(8'hB9, 0);
    @(negedge clk); err_clear = 1; host_wr = 1; host_wr_word = {8'hBA, 56'h0};
    @(negedge clk); err_clear = 0; host_wr = 0; wq.delete();
    chk("R7 clear overrides write", occupancy, 0);
    chk("R7 stream idle after clear", bus_out_valid, 0);

    // Residual exhausted.
    pace_en = 0;
    load(16'd1);
    host_write(8'hC0, 1);
    chk("R6 residual at zero", residual, 0);
    chk("R6 no flag yet", err_access, 0);
    host_write(8'hC1, 1);
    chk("R6 exhausted flag", err_access, 1);
    chk("R6 residual stays zero", residual, 0);
    chk("R6 byte still stored", occupancy, 2);
    drain();
    chk("R6 exhausted bytes sent", wq.size(), 0);
    clear_all();

    // Host push and engine pop in the same cycle.
    load(16'd20);
    for (int i = 0; i < 3; i++) host_write(8'hD0 + 8'(i), 1);
    @(negedge clk);
    host_wr = 1; host_wr_word = {8'hD3, 56'h0}; wq.push_back(8'hD3); bus_out_ready = 1;
    @(negedge clk);
    host_wr = 0; bus_out_ready = 0;
    chk("R8 net occupancy", occupancy, 3);
    chk("R8 residual", residual, 16);
    drain();
    chk("R8 bytes sent", wq.size(), 0);

    // Engine output held off when no transfer runs.
    host_write(8'hE0, 1);
    @(negedge clk); xfer_active = 0;
    @(negedge clk);
    chk("R9 output gated", bus_out_valid, 0);
    chk("R9 data kept", occupancy, 1);
    xfer_active = 1;
    clear_all();

    // Read transfer.
    xfer_is_read = 1; pace_en = 0;
    load(16'd10);
    for (int i = 0; i < 9; i++) bus_push(8'hF0 + 8'(i));
    chk("R9 accepted received bytes", rq.size(), 8);
    chk("R9 input stalled when full", bus_in_ready, 0);
    chk("R9 no flag from stall", {err_invalid, err_overrun, err_access}, 0);
    chk("R6 engine leaves residual", residual, 10);
    for (int i = 0; i < 8; i++) host_read(1, "R3 read order");
    chk("R6 residual after reads", residual, 2);
    chk("R5 empty after reads", occupancy, 0);
    host_read(0, "R4 empty read keeps word");
    chk("R4 empty read flag", err_overrun, 1);
    host_write(8'h77, 0);
    chk("R2 write during read flag", err_invalid, 1);
    chk("R2 write during read occupancy", occupancy, 0);
    clear_all();
    pace_en = 1;
    host_read(0, "R4 paced empty read word");
    chk("R4 paced empty read flag", err_overrun, 0);

    summary();
    $finish;
  end
endmodule